// File: doc/BRIEF.md
# Phase-Shifted Carrier Gate Generator for a Nine-Arm Converter Phase

This block produces the sub-module switching states for one phase leg of a three-port, nine-arm modular converter. A single phase counter drives N triangular carriers, each displaced from its neighbour by an equal fraction of the carrier period. Each carrier is compared with two signed references, one for each AC port. The upper-arm state is set when the upper reference lies above the carrier. The lower-arm state is set when the lower reference lies below it. The middle-arm state is the exclusive-or of those two.

The references are captured only at the peak of carrier 0, so a new value never splits a switching period. A DC-side current sample is compared with a programmable threshold. An overcurrent latches an inhibit that holds every gate low until software asks for release while the current is back in range. A status output flags captured references whose order is inverted, and this flag has no effect on the gating.

All quantities share one scale. A reference or carrier value of +P means +1 and −P means −1, where P is the half-period count. With the default P of 31250 at 125 MHz, the carrier runs at 2 kHz.

Top module: `nine_arm_pwm`

## Requirements
- R1: While reset is asserted, and afterwards until the first reference capture, every gate output is 0. After reset, fault_o and order_err_o are 0 and the half-period register holds DEF_HALF (default 31250).
- R2: A phase count ph steps by one per clock over 0..2P−1 and then returns to 0. The value of half_period_i is taken into P only on the clock where ph wraps. Carrier 0 equals 2·t−P, where t = ph if ph ≤ P and t = 2P−ph otherwise.
- R3: Carrier i is carrier 0's formula evaluated at (ph + floor(2P·i/N)) mod 2P, which spaces the carriers evenly over the period.
- R4: Upper gate i is 1 when the captured upper reference, read as signed, is strictly greater than carrier i.
- R5: Lower gate i is 1 when the captured lower reference, read as signed, is strictly less than carrier i.
- R6: Middle gate i equals upper gate i XOR lower gate i.
- R7: Both references are captured on the clock edge at which ph equals P, and the captured values take effect from the next cycle. A change at any other time leaves the gates unaffected until that edge.
- R8: If cur_i > cur_thresh_i (unsigned) at a clock edge, fault_o is 1 from the next cycle, and while fault_o is 1 all 3·N gates are 0. A current equal to the threshold does not set the fault.
- R9: Once fault_o is set, it clears at an edge only if fault_clear_i is 1 and cur_i ≤ cur_thresh_i. In every other case it stays set.
- R10: order_err_o is 1 while the captured upper reference is below the captured lower reference (signed). The gates still follow R4 to R6.
- R11: A half_period_i value below N is taken as N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | HALF_W (15) | Requested half-period count P |
| ref_up_i | input | DATA_W (16) | Upper-port reference, signed |
| ref_lo_i | input | DATA_W (16) | Lower-port reference, signed |
| cur_i | input | CUR_W (16) | DC-side current sample, unsigned |
| cur_thresh_i | input | CUR_W (16) | Overcurrent threshold, unsigned |
| fault_clear_i | input | 1 | Request to release the fault inhibit |
| gate_up_o | output | N_SM (4) | Upper-arm sub-module states |
| gate_mid_o | output | N_SM (4) | Middle-arm sub-module states |
| gate_lo_o | output | N_SM (4) | Lower-arm sub-module states |
| fault_o | output | 1 | Latched overcurrent inhibit |
| order_err_o | output | 1 | Captured references in inverted order |

## Verification
The assertions check on every cycle that the phase count stays within its period, that P never drops below N, and that every carrier stays within ±P. They also check that the captured references move only at the carrier-0 peak, that an overcurrent always latches the inhibit and that the inhibit holds without a valid clear, and that no gate is active while inhibited or before the first capture. The exact carrier shapes, the phase offsets between indices, the signed comparisons and XOR results, the timing of period changes, the lower clamp and the order flag can only be shown by the bench's scenarios. The bench compares every output on every cycle against a model built from the requirements.

// File: rtl/na_pwm_pkg.sv
package na_pwm_pkg;

  // phase + offset, folded into one carrier period
  function automatic logic [31:0] wrap_add(logic [31:0] ph, logic [31:0] off,
                                           logic [31:0] per2);
    logic [31:0] s;
    s = ph + off;
    if (s >= per2) s = s - per2;
    return s;
  endfunction

  // triangle position -> signed carrier in [-half, +half]
  function automatic logic signed [31:0] fold_tri(logic [31:0] pos, logic [31:0] half);
    logic [31:0] t;
    t = (pos <= half) ? pos : ((half << 1) - pos);
    return $signed(t << 1) - $signed(half);
  endfunction

endpackage

// File: rtl/na_carrier_gen.sv
module na_carrier_gen
  import na_pwm_pkg::*;
#(
  parameter int N_SM     = 4,
  parameter int HALF_W   = 15,
  parameter int DATA_W   = 16,
  parameter int DEF_HALF = 31250
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [HALF_W-1:0]             half_period_i,
  output logic [N_SM-1:0][DATA_W-1:0]   carrier_o,
  output logic                          peak_o
);
  localparam int PH_W = HALF_W + 1;
  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(N_SM);
  localparam logic [HALF_W-1:0] RST_HALF = HALF_W'(DEF_HALF);

  logic [HALF_W-1:0] half_q, half_nxt;
  logic [PH_W-1:0]   ph_q, per2;
  logic              wrap;

  assign per2     = {half_q, 1'b0};
  assign wrap     = (ph_q == per2 - PH_W'(1));
  assign half_nxt = (half_period_i < MIN_HALF) ? MIN_HALF : half_period_i;
  assign peak_o   = (ph_q == {1'b0, half_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      half_q <= RST_HALF;
    end else if (wrap) begin
      ph_q   <= '0;
      half_q <= half_nxt;
    end else begin
      ph_q   <= ph_q + PH_W'(1);
    end
  end

  for (genvar i = 0; i < N_SM; i++) begin : g_car
    logic [31:0]        off, pos;
    logic signed [31:0] val;
    always_comb begin
      off = (32'(per2) * 32'(i)) / 32'(N_SM);
      pos = wrap_add(32'(ph_q), off, 32'(per2));
      val = fold_tri(pos, 32'(half_q));
    end
    assign carrier_o[i] = DATA_W'(val);

    AST_CARRIER_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'($signed(carrier_o[i])) <= int'(half_q)) &&
      (int'($signed(carrier_o[i])) >= -int'(half_q))); // R3
  end

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < per2); // R2
  AST_HALF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q >= MIN_HALF); // R11
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ph_q == $past(ph_q) + PH_W'(1)); // R2

endmodule

// File: rtl/na_arm_cmp.sv
module na_arm_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] carrier_i,
  input  logic [DATA_W-1:0] ref_up_i,
  input  logic [DATA_W-1:0] ref_lo_i,
  input  logic              enable_i,
  output logic              up_o,
  output logic              lo_o,
  output logic              mid_o
);
  logic up_raw, lo_raw;

  always_comb begin
    up_raw = $signed(ref_up_i) > $signed(carrier_i);
    lo_raw = $signed(ref_lo_i) < $signed(carrier_i);
    up_o   = enable_i & up_raw;
    lo_o   = enable_i & lo_raw;
    mid_o  = enable_i & (up_raw ^ lo_raw);
  end

endmodule

// File: rtl/na_fault_latch.sv
module na_fault_latch #(
  parameter int CUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [CUR_W-1:0] thresh_i,
  input  logic             clear_i,
  output logic             fault_o
);
  logic over;
  assign over = cur_i > thresh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fault_o <= 1'b0;
    else if (over)              fault_o <= 1'b1;
    else if (clear_i)           fault_o <= 1'b0;
  end

  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> fault_o); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !clear_i |=> fault_o); // R9
  AST_FAULT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && clear_i && !over |=> !fault_o); // R9

endmodule

// File: rtl/nine_arm_pwm.sv
module nine_arm_pwm #(
  parameter int N_SM     = 4,
  parameter int HALF_W   = 15,
  parameter int DATA_W   = 16,
  parameter int CUR_W    = 16,
  parameter int DEF_HALF = 31250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_period_i,
  input  logic [DATA_W-1:0] ref_up_i,
  input  logic [DATA_W-1:0] ref_lo_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [CUR_W-1:0]  cur_thresh_i,
  input  logic              fault_clear_i,
  output logic [N_SM-1:0]   gate_up_o,
  output logic [N_SM-1:0]   gate_mid_o,
  output logic [N_SM-1:0]   gate_lo_o,
  output logic              fault_o,
  output logic              order_err_o
);
  logic [N_SM-1:0][DATA_W-1:0] carrier;
  logic                        peak;
  logic [DATA_W-1:0]           ref_up_q, ref_lo_q;
  logic                        armed_q, enable;

  na_carrier_gen #(
    .N_SM(N_SM), .HALF_W(HALF_W), .DATA_W(DATA_W), .DEF_HALF(DEF_HALF)
  ) u_car (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_period_i(half_period_i),
    .carrier_o(carrier), .peak_o(peak)
  );

  na_fault_latch #(.CUR_W(CUR_W)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(cur_i), .thresh_i(cur_thresh_i),
    .clear_i(fault_clear_i), .fault_o(fault_o)
  );

  // references move only at carrier-0 peak
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_up_q <= '0;
      ref_lo_q <= '0;
      armed_q  <= 1'b0;
    end else if (peak) begin
      ref_up_q <= ref_up_i;
      ref_lo_q <= ref_lo_i;
      armed_q  <= 1'b1;
    end
  end

  assign enable      = armed_q & ~fault_o;
  assign order_err_o = $signed(ref_up_q) < $signed(ref_lo_q);

  for (genvar i = 0; i < N_SM; i++) begin : g_arm
    na_arm_cmp #(.DATA_W(DATA_W)) u_cmp (
      .carrier_i(carrier[i]), .ref_up_i(ref_up_q), .ref_lo_i(ref_lo_q),
      .enable_i(enable), .up_o(gate_up_o[i]), .lo_o(gate_lo_o[i]),
      .mid_o(gate_mid_o[i])
    );
  end

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak |=> $stable(ref_up_q) && $stable(ref_lo_q)); // R7
  AST_INHIBIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (gate_up_o == '0) && (gate_mid_o == '0) && (gate_lo_o == '0)); // R8
  AST_UNARMED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (gate_up_o == '0) && (gate_mid_o == '0) && (gate_lo_o == '0)); // R1

endmodule

// File: tb/nine_arm_pwm_tb.sv
`timescale 1ns/1ps
module nine_arm_pwm_tb;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] half_period_i = 15'd8;
  logic [15:0] ref_up_i = '0, ref_lo_i = '0;
  logic [15:0] cur_i = '0, cur_thresh_i = 16'd100;
  logic        fault_clear_i = 1'b0;
  logic [N-1:0] gate_up_o, gate_mid_o, gate_lo_o;
  logic        fault_o, order_err_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  nine_arm_pwm u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_period_i(half_period_i),
    .ref_up_i(ref_up_i), .ref_lo_i(ref_lo_i), .cur_i(cur_i),
    .cur_thresh_i(cur_thresh_i), .fault_clear_i(fault_clear_i),
    .gate_up_o(gate_up_o), .gate_mid_o(gate_mid_o), .gate_lo_o(gate_lo_o),
    .fault_o(fault_o), .order_err_o(order_err_o)
  );

  // reference model built from the requirements
  int m_ph, m_half, m_ru, m_rl;
  bit m_armed, m_fault;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_half = 31250; m_ru = 0; m_rl = 0; m_armed = 0; m_fault = 0;
    end else begin
      if (m_ph == m_half) begin           // R7 capture at carrier-0 peak
        m_ru = int'($signed(ref_up_i));
        m_rl = int'($signed(ref_lo_i));
        m_armed = 1;
      end
      if (m_ph == 2 * m_half - 1) begin   // R2 wrap, R11 clamp
        m_ph = 0;
        m_half = (int'(half_period_i) < N) ? N : int'(half_period_i);
      end else m_ph = m_ph + 1;
      if (cur_i > cur_thresh_i) m_fault = 1;           // R8
      else if (fault_clear_i) m_fault = 0;             // R9
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_now(string scen);
    logic [N-1:0] eu, el, em;
    for (int i = 0; i < N; i++) begin
      int off, pos, t, c;
      off = (2 * m_half * i) / N;                       // R3
      pos = (m_ph + off) % (2 * m_half);
      t = (pos <= m_half) ? pos : 2 * m_half - pos;
      c = 2 * t - m_half;
      eu[i] = m_armed && !m_fault && (m_ru > c);
      el[i] = m_armed && !m_fault && (m_rl < c);
      em[i] = eu[i] ^ el[i];
    end
    chk({"R4 ", scen}, "gate_up", int'(gate_up_o), int'(eu));
    chk({"R5 ", scen}, "gate_lo", int'(gate_lo_o), int'(el));
    chk({"R6 ", scen}, "gate_mid", int'(gate_mid_o), int'(em));
    chk({"R8 ", scen}, "fault", int'(fault_o), int'(m_fault));
    chk({"R10 ", scen}, "order_err", int'(order_err_o), int'(m_ru < m_rl));
  endtask

  task automatic run(string scen, int cycles);
    repeat (cycles) begin
      @(negedge clk_i);
      check_now(scen);
    end
  endtask

  task automatic t_reset;   // R1
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", "gates in reset", int'({gate_up_o, gate_mid_o, gate_lo_o}), 0);
      chk("R1", "flags in reset", int'({fault_o, order_err_o}), 0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_default_period;   // R1 R2: default P, unarmed until peak
    ref_up_i = 16'(20000); ref_lo_i = 16'(-10000);
    half_period_i = 15'd8;
    run("R2 default period", 62520);
  endtask

  task automatic t_patterns;   // R3 R4 R5 R6
    ref_up_i = 16'(5);  ref_lo_i = 16'(-3); run("R3 pattern a", 40);
    ref_up_i = 16'(8);  ref_lo_i = 16'(-8); run("R3 full scale", 40);
    ref_up_i = 16'(0);  ref_lo_i = 16'(0);  run("R3 zero refs", 40);
    ref_up_i = 16'(7);  ref_lo_i = 16'(6);  run("R3 narrow band", 40);
  endtask

  task automatic t_capture;   // R7: changes away from the peak
    ref_up_i = 16'(2); ref_lo_i = 16'(-2); run("R7 a", 3);
    ref_up_i = 16'(-1); ref_lo_i = 16'(-6); run("R7 b", 5);
    ref_up_i = 16'(6); ref_lo_i = 16'(1); run("R7 c", 30);
  endtask

  task automatic t_order;   // R10
    ref_up_i = 16'(-5); ref_lo_i = 16'(5); run("R10 inverted", 40);
    ref_up_i = 16'(4); ref_lo_i = 16'(-4); run("R10 restored", 40);
  endtask

  task automatic t_fault;   // R8 R9
    cur_thresh_i = 16'd100;
    cur_i = 16'd100; run("R8 equal threshold", 5);
    cur_i = 16'd101; run("R8 over", 5);
    fault_clear_i = 1'b1; run("R9 clear while over", 5);
    fault_clear_i = 1'b0; cur_i = 16'd50; run("R9 no clear", 5);
    fault_clear_i = 1'b1; run("R9 release", 2);
    fault_clear_i = 1'b0; run("R9 after release", 30);
    chk("R9", "fault released", int'(fault_o), 0);
  endtask

  task automatic t_period;   // R2 R11
    half_period_i = 15'd6; run("R2 new period", 40);
    half_period_i = 15'd1; run("R11 clamp", 40);
    half_period_i = 15'd0; run("R11 clamp zero", 40);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_default_period();
    t_patterns();
    t_capture();
    t_order();
    t_fault();
    t_period();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule